// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Error Flags

This block recovers bytes from a single asynchronous serial line. A divider derives a sampling tick at sixteen times the bit rate. A start bit is accepted only if the line is still low at the middle of the bit. Each later bit is then sampled at its centre and shifted into a receive shift register. When a frame ends, the byte and the frame's status go to a holding data register and four sticky flags: byte ready, overrun, bad stop bit and parity mismatch.

Software sees the data register and the flags directly as outputs. It clears each flag with its own one-cycle clear strobe. Reading the data register has no side effect. Two level interrupt requests are derived from the flags. One is raised while a byte is ready, the other while any error flag is set, and both are gated by a single enable input.

Any error stops the receiver. It ignores the line until software has cleared the ready flag and all three error flags. Overrun and framing/parity errors differ in one way: an overrun keeps the older byte, while framing and parity errors still store the new byte.

Top module: `serial_rx_core`

## Requirements
- R1: A frame is a start bit (0), eight data bits with the least significant bit first, an optional parity bit, and a stop bit (1), on a line that idles at 1. When a frame completes without error and the ready flag is 0, the byte is stored in `rx_byte` and `st_ready` becomes 1.
- R2: If a frame completes while `st_ready` is 1, `st_overrun` becomes 1, `rx_byte` keeps its old value and `st_ready` stays 1.
- R3: If the sampled stop bit is 0, `st_frame_err` becomes 1 and the byte is still stored, while `st_ready` keeps its previous value.
- R4: When `cfg_par_en` is 1, the parity bit must make the number of ones in data plus parity even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1). On a mismatch `st_par_err` becomes 1, the byte is still stored and `st_ready` keeps its previous value.
- R5: When `cfg_par_en` is 0, the frame carries no parity bit (the stop bit follows data bit 7) and `st_par_err` is never set, whatever `cfg_par_odd` is.
- R6: After any error, no frame is received until `st_ready`, `st_overrun`, `st_frame_err` and `st_par_err` are all 0. Frames sent during that time change neither the flags nor `rx_byte`.
- R7: A one-cycle pulse on `clr_ready`, `clr_overrun`, `clr_frame_err` or `clr_par_err` clears only the matching flag.
- R8: `irq_rx_full` equals `irq_en` AND `st_ready`. `irq_rx_err` equals `irq_en` AND the OR of the three error flags.
- R9: A low pulse on the idle line shorter than half a bit is not taken as a start bit and produces no byte.
- R10: After reset all flags, both interrupt outputs and `rx_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idles high |
| cfg_par_en | input | 1 | 1: frame carries a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| irq_en | input | 1 | Enable for both interrupt requests |
| clr_ready | input | 1 | Clear strobe for the ready flag |
| clr_overrun | input | 1 | Clear strobe for the overrun flag |
| clr_frame_err | input | 1 | Clear strobe for the framing-error flag |
| clr_par_err | input | 1 | Clear strobe for the parity-error flag |
| rx_byte | output | 8 | Data register |
| st_ready | output | 1 | Byte-ready flag |
| st_overrun | output | 1 | Overrun flag |
| st_frame_err | output | 1 | Framing-error flag |
| st_par_err | output | 1 | Parity-error flag |
| irq_rx_full | output | 1 | Receive-full interrupt request (level) |
| irq_rx_err | output | 1 | Receive-error interrupt request (level) |

## Verification
The bench builds the receiver with `CLK_PER_TICK` = 2, so one bit lasts 32 clocks and a whole frame fits in a few hundred cycles. This makes room for many back-to-back frames, including frames sent while the receiver is blocked. `OVERSAMPLE` stays at 16 and `DATA_W` at 8. The default mid-bit timing is therefore exercised, and a glitch of three ticks sits clearly below the half-bit acceptance point.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic ready;
    logic overrun;
    logic frame_err;
    logic par_err;
  } rx_flags_t;

endpackage

// File: rtl/rx_reset_sync.sv
module rx_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], din};
  end

  assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/rx_baud_tick.sv
module rx_baud_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every_cycle
      assign tick = 1'b1;
    end else begin : g_divider
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == LAST);

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = wrap;
    end
  endgenerate
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              arm,
  input  logic              par_en,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_bit,
  output logic              stop_bit
);
  localparam int CW = $clog2(OVS);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID_START = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_W - 1);

  rx_state_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              stop_q, stop_d;
  logic              done_q, done_d;
  logic              at_centre;

  assign at_centre = (cnt_q == BIT_LAST);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    stop_d = stop_q;
    done_d = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (tick && arm && !rxd_s) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == MID_START) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (at_centre) begin
            cnt_d = '0;
            sh_d  = {rxd_s, sh_q[DATA_W-1:1]};
            if (idx_q == IDX_LAST) st_d = par_en ? RX_PAR : RX_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_PAR: begin
        if (tick) begin
          if (at_centre) begin
            cnt_d = '0;
            par_d = rxd_s;
            st_d  = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (at_centre) begin
            cnt_d  = '0;
            stop_d = rxd_s;
            done_d = 1'b1;
            st_d   = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      stop_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      stop_q <= stop_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign data     = sh_q;
  assign par_bit  = par_q;
  assign stop_bit = stop_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int CLK_PER_TICK = 4,
  parameter int OVERSAMPLE   = 16,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              irq_en,
  input  logic              clr_ready,
  input  logic              clr_overrun,
  input  logic              clr_frame_err,
  input  logic              clr_par_err,
  output logic [DATA_W-1:0] rx_byte,
  output logic              st_ready,
  output logic              st_overrun,
  output logic              st_frame_err,
  output logic              st_par_err,
  output logic              irq_rx_full,
  output logic              irq_rx_err
);
  logic              rst_n_i;
  logic              tick;
  logic              rxd_s;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_par;
  logic              frame_stop;
  logic              rx_hold;

  rx_flags_t         flags_q, flags_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              hold_q, hold_d;

  rx_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .din(rxd), .dout(rxd_s)
  );

  rx_baud_tick #(.DIV(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n_i), .tick(tick)
  );

  rx_frame_fsm #(.OVS(OVERSAMPLE), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_i), .tick(tick), .rxd_s(rxd_s),
    .arm(!rx_hold), .par_en(cfg_par_en),
    .done(frame_done), .data(frame_data),
    .par_bit(frame_par), .stop_bit(frame_stop)
  );

  assign rx_hold = hold_q;

  logic ev_ovr, ev_frm, ev_par, ev_any, want_par;

  always_comb begin
    want_par = (^frame_data) ^ cfg_par_odd;
    ev_ovr   = frame_done && flags_q.ready;
    ev_frm   = frame_done && !frame_stop;
    ev_par   = frame_done && cfg_par_en && (frame_par != want_par);
    ev_any   = ev_ovr || ev_frm || ev_par;

    flags_d.ready     = flags_q.ready     && !clr_ready;
    flags_d.overrun   = flags_q.overrun   && !clr_overrun;
    flags_d.frame_err = flags_q.frame_err && !clr_frame_err;
    flags_d.par_err   = flags_q.par_err   && !clr_par_err;
    byte_d            = byte_q;

    if (frame_done && !ev_any) flags_d.ready = 1'b1;
    if (ev_ovr)                flags_d.overrun   = 1'b1;
    if (ev_frm)                flags_d.frame_err = 1'b1;
    if (ev_par)                flags_d.par_err   = 1'b1;
    if (frame_done && !ev_ovr) byte_d = frame_data;

    if (ev_any) hold_d = 1'b1;
    else        hold_d = hold_q && (flags_q.ready || flags_q.overrun ||
                                    flags_q.frame_err || flags_q.par_err);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      flags_q <= '0;
      byte_q  <= '0;
      hold_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      byte_q  <= byte_d;
      hold_q  <= hold_d;
    end
  end

  assign rx_byte      = byte_q;
  assign st_ready     = flags_q.ready;
  assign st_overrun   = flags_q.overrun;
  assign st_frame_err = flags_q.frame_err;
  assign st_par_err   = flags_q.par_err;
  assign irq_rx_full  = irq_en && flags_q.ready;
  assign irq_rx_err   = irq_en && (flags_q.overrun || flags_q.frame_err || flags_q.par_err);
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic              rx_hold,
  input logic              cfg_par_en,
  input logic              clr_ready,
  input logic [DATA_W-1:0] rx_byte,
  input logic              st_ready,
  input logic              st_overrun,
  input logic              st_frame_err,
  input logic              st_par_err
);
  p_ready_from_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ready) |-> $past(frame_done));

  p_overrun_keeps_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_overrun) |-> $stable(rx_byte));

  p_frame_err_keeps_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_frame_err) && !$past(clr_ready)) |-> $stable(st_ready));

  p_par_err_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_par_err) |-> $past(cfg_par_en));

  p_no_frame_while_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hold |-> !frame_done);

  p_frame_err_from_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_frame_err) |-> $past(frame_done));
endmodule

bind serial_rx_core serial_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rx_hold(rx_hold),
  .cfg_par_en(cfg_par_en), .clr_ready(clr_ready), .rx_byte(rx_byte),
  .st_ready(st_ready), .st_overrun(st_overrun),
  .st_frame_err(st_frame_err), .st_par_err(st_par_err)
);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int OVS        = 16;
  localparam int BIT_CLK    = DIV * OVS;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b1;
  logic       c_rdy = 1'b0, c_ovr = 1'b0, c_frm = 1'b0, c_par = 1'b0;
  logic [7:0] rx_byte;
  logic       st_ready, st_overrun, st_frame_err, st_par_err;
  logic       irq_rx_full, irq_rx_err;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_core #(.CLK_PER_TICK(DIV), .OVERSAMPLE(OVS), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd),
    .cfg_par_en(par_en), .cfg_par_odd(par_odd), .irq_en(irq_en),
    .clr_ready(c_rdy), .clr_overrun(c_ovr), .clr_frame_err(c_frm), .clr_par_err(c_par),
    .rx_byte(rx_byte), .st_ready(st_ready), .st_overrun(st_overrun),
    .st_frame_err(st_frame_err), .st_par_err(st_par_err),
    .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err)
  );

  typedef struct packed {
    logic       clr;
    logic       pe;
    logic       po;
    logic       bad_stop;
    logic       bad_par;
    logic [7:0] data;
    logic       e_rdy;
    logic       e_ovr;
    logic       e_frm;
    logic       e_par;
    logic [7:0] e_byte;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,8'hA5, 1'b1,1'b0,1'b0,1'b0,8'hA5},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h3C, 1'b1,1'b0,1'b0,1'b0,8'h3C},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h07, 1'b1,1'b0,1'b0,1'b0,8'h07},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,8'h81, 1'b1,1'b0,1'b0,1'b0,8'h81},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,8'h5A, 1'b0,1'b0,1'b0,1'b1,8'h5A},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h0F, 1'b0,1'b0,1'b1,1'b0,8'h0F},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,8'h11, 1'b1,1'b0,1'b0,1'b0,8'h11},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h22, 1'b1,1'b1,1'b0,1'b0,8'h11},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h33, 1'b1,1'b1,1'b0,1'b0,8'h11},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,8'h44, 1'b0,1'b0,1'b0,1'b1,8'h44}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input bit rdy, input bit ovr,
                             input bit frm, input bit par, input logic [7:0] b);
    check(st_ready == rdy,     tag, "ready",     st_ready, rdy);
    check(st_overrun == ovr,   tag, "overrun",   st_overrun, ovr);
    check(st_frame_err == frm, tag, "frame_err", st_frame_err, frm);
    check(st_par_err == par,   tag, "par_err",   st_par_err, par);
    check(rx_byte == b,        tag, "rx_byte",   rx_byte, b);
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pe, input bit po,
                            input bit bad_stop, input bit bad_par);
    logic p;
    p = (^d) ^ po;
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (pe) hold_bit(bad_par ? ~p : p);
    hold_bit(bad_stop ? 1'b0 : 1'b1);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic pulse_clear(input bit r, input bit o, input bit f, input bit p);
    @(negedge clk);
    c_rdy = r; c_ovr = o; c_frm = f; c_par = p;
    @(negedge clk);
    c_rdy = 1'b0; c_ovr = 1'b0; c_frm = 1'b0; c_par = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    check_state("R10", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check(irq_rx_full == 1'b0 && irq_rx_err == 1'b0, "R10", "irqs",
          {irq_rx_full, irq_rx_err}, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].clr) pulse_clear(1'b1, 1'b1, 1'b1, 1'b1);
      par_en  = VEC[v].pe;
      par_odd = VEC[v].po;
      send_frame(VEC[v].data, VEC[v].pe, VEC[v].po, VEC[v].bad_stop, VEC[v].bad_par);
      if (v == 8)              tag = "R6";
      else if (VEC[v].e_ovr)   tag = "R2";
      else if (VEC[v].e_frm)   tag = "R3";
      else if (VEC[v].e_par)   tag = "R4";
      else if (!VEC[v].pe)     tag = "R5";
      else                     tag = "R1";
      check_state(tag, VEC[v].e_rdy, VEC[v].e_ovr, VEC[v].e_frm, VEC[v].e_par,
                  VEC[v].e_byte);
      // R8: interrupt levels follow the flags
      check(irq_rx_full == VEC[v].e_rdy, "R8", "irq_rx_full", irq_rx_full, VEC[v].e_rdy);
      check(irq_rx_err == (VEC[v].e_ovr | VEC[v].e_frm | VEC[v].e_par), "R8",
            "irq_rx_err", irq_rx_err, VEC[v].e_ovr | VEC[v].e_frm | VEC[v].e_par);
    end

    // R8: enable low masks both requests
    irq_en = 1'b0;
    @(negedge clk);
    check(irq_rx_err == 1'b0 && irq_rx_full == 1'b0, "R8", "masked irqs",
          {irq_rx_full, irq_rx_err}, 0);
    irq_en = 1'b1;

    // R7 and R6: partial clears keep the receiver blocked
    pulse_clear(1'b1, 1'b1, 1'b1, 1'b1);
    par_en = 1'b0; par_odd = 1'b0;
    send_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
    check_state("R1", 1'b1, 1'b0, 1'b0, 1'b0, 8'h55);
    send_frame(8'h66, 1'b0, 1'b0, 1'b0, 1'b0);
    check_state("R2", 1'b1, 1'b1, 1'b0, 1'b0, 8'h55);
    pulse_clear(1'b0, 1'b1, 1'b0, 1'b0);
    check_state("R7", 1'b1, 1'b0, 1'b0, 1'b0, 8'h55);
    send_frame(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    check_state("R6", 1'b1, 1'b0, 1'b0, 1'b0, 8'h55);
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
    check_state("R7", 1'b0, 1'b0, 1'b0, 1'b0, 8'h55);
    send_frame(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    check_state("R6", 1'b1, 1'b0, 1'b0, 1'b0, 8'h77);

    // R5: parity disabled ignores odd select
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
    par_odd = 1'b1;
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);
    check_state("R5", 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3);

    // R9: short low glitch is rejected
    pulse_clear(1'b1, 1'b0, 1'b0, 1'b0);
    rxd = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    check_state("R9", 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3);
    send_frame(8'h99, 1'b0, 1'b0, 1'b0, 1'b0);
    check_state("R9", 1'b1, 1'b0, 1'b0, 1'b0, 8'h99);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule